// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block forms the effective address of a memory-format instruction: loads, stores and indirect branches that name their target through a base register, an index register, an in-word offset or a trailing 32-bit displacement word. The caller presents the first instruction word, the displacement word (don't-care for short forms), and the address of the instruction, together with a one-cycle `inValid` strobe.

Two register numbers are decoded from the instruction word and driven out as read addresses in the same cycle. The register file returns base and index values combinationally in that same cycle. One clock later the block presents the address, the data register number (the load destination or store source) and a flag that marks an encoding with no defined addressing mode. The memory access itself is the job of the stage that follows.

The instruction word carries the data register in bits 23:19, the base register in 18:14, the addressing mode in 13:10, a scale code in 9:7, two reserved bits in 6:5 and the index register in 4:0. Mode bit 2 selects between the short form, which takes an unsigned 12-bit offset from bits 11:0, and the long form.

Top module: `memEaGen`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and low otherwise. After reset, `outValid`, `effAddr`, `dataReg` and `invalidMode` are all zero.
- R2: `baseRegAddr` equals instruction bits 18:14 and `indexRegAddr` equals bits 4:0, combinationally in the cycle `inValid` is high.
- R3: `dataReg` carries instruction bits 23:19 of the accepted instruction.
- R4: Short form (mode bit 2 = 0): the address is bits 11:0 zero-extended. The base register value is added when mode bit 3 = 1. The short form is never invalid, whatever bits 9:5 hold.
- R5: Mode 4 gives the base value. Mode 5 gives displacement + 8 + instruction address.
- R6: Mode 7 gives base + (index << scale).
- R7: Mode 12 gives the displacement. Mode 13 gives displacement + base.
- R8: Mode 14 gives displacement + (index << scale). Mode 15 gives displacement + base + (index << scale).
- R9: Scale codes 0 to 4 multiply the index by 1, 2, 4, 8 and 16. In the long form, a code of 5 to 7 raises `invalidMode`.
- R10: In the long form, a nonzero value in bits 6:5 raises `invalidMode`.
- R11: Mode 6 raises `invalidMode`.
- R12: When `invalidMode` is high, `effAddr` is zero. All additions wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction presented this cycle |
| instrWord | input | 32 | First instruction word |
| dispWord | input | ADDR_W | Displacement word for long modes 5 and 12-15 |
| instrAddr | input | ADDR_W | Address of the instruction |
| baseRegAddr | output | REG_W | Base register read address |
| indexRegAddr | output | REG_W | Index register read address |
| baseRegData | input | ADDR_W | Base register value, same cycle |
| indexRegData | input | ADDR_W | Index register value, same cycle |
| outValid | output | 1 | Result valid |
| effAddr | output | ADDR_W | Effective address (zero when invalid) |
| dataReg | output | REG_W | Load destination or store source register |
| invalidMode | output | 1 | Encoding has no defined addressing mode |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 5-bit register numbers, an instruction-relative bias of 8, and a largest shift of 4. With these defaults, the scale codes that sit on both sides of the validity limit can be driven, so code 4 (factor 16) is tested next to codes 5 to 7. Base and displacement values near 2^32 make the wrap of every adder chain visible at the output. The register-file model mixes the requested register number into the returned value, so a wrong read address shows up as a wrong sum.

// File: rtl/memEaPkg.sv
package memEaPkg;
  localparam int INSTR_W = 32;

  localparam logic [3:0] MODE_BASE      = 4'd4;
  localparam logic [3:0] MODE_IPREL     = 4'd5;
  localparam logic [3:0] MODE_RESERVED  = 4'd6;
  localparam logic [3:0] MODE_BASE_IDX  = 4'd7;
  localparam logic [3:0] MODE_DISP      = 4'd12;
  localparam logic [3:0] MODE_DISP_BASE = 4'd13;
  localparam logic [3:0] MODE_DISP_IDX  = 4'd14;
  localparam logic [3:0] MODE_DISP_ALL  = 4'd15;

  typedef struct packed {
    logic       useShort;
    logic       useBase;
    logic       useIndex;
    logic       useDisp;
    logic       useIp;
    logic       invalid;
    logic [2:0] shiftAmt;
  } eaStrobes_t;
endpackage

// File: rtl/memEaCtrl.sv
module memEaCtrl
  import memEaPkg::*;
#(
  parameter int MAX_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instrWord,
  output eaStrobes_t          strb
);
  logic [3:0] mode;
  logic [2:0] scaleCode;
  logic [1:0] rsvdBits;
  logic       longForm;
  logic       badLong;

  assign mode      = instrWord[13:10];
  assign scaleCode = instrWord[9:7];
  assign rsvdBits  = instrWord[6:5];
  assign longForm  = mode[2];
  assign badLong   = (int'(scaleCode) > MAX_SHIFT) || (rsvdBits != 2'b00)
                     || (mode == MODE_RESERVED);

  always_comb begin
    strb = '0;
    strb.shiftAmt = scaleCode;
    if (!longForm) begin
      strb.useShort = 1'b1;
      strb.useBase  = mode[3];
    end else if (badLong) begin
      strb.invalid  = 1'b1;
    end else begin
      unique case (mode)
        MODE_BASE:      strb.useBase = 1'b1;
        MODE_IPREL:     begin strb.useDisp = 1'b1; strb.useIp = 1'b1; end
        MODE_BASE_IDX:  begin strb.useBase = 1'b1; strb.useIndex = 1'b1; end
        MODE_DISP:      strb.useDisp = 1'b1;
        MODE_DISP_BASE: begin strb.useDisp = 1'b1; strb.useBase = 1'b1; end
        MODE_DISP_IDX:  begin strb.useDisp = 1'b1; strb.useIndex = 1'b1; end
        MODE_DISP_ALL:  begin strb.useDisp = 1'b1; strb.useBase = 1'b1;
                              strb.useIndex = 1'b1; end
        default:        strb.invalid = 1'b1;
      endcase
    end
  end

  // R9
  scale_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.useIndex) |-> (int'(strb.shiftAmt) <= MAX_SHIFT));

  // R10
  rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[12] && (instrWord[6:5] != 2'b00)) |-> strb.invalid);

  // R4
  short_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !instrWord[12]) |-> (!strb.invalid && strb.useShort));
endmodule

// File: rtl/memEaDatapath.sv
module memEaDatapath
  import memEaPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 5,
  parameter int IP_BIAS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic [ADDR_W-1:0]   dispWord,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic [ADDR_W-1:0]   baseRegData,
  input  logic [ADDR_W-1:0]   indexRegData,
  input  eaStrobes_t          strb,
  output logic                outValid,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [REG_W-1:0]    dataReg,
  output logic                invalidMode
);
  localparam int OFFSET_W = 12;

  logic [ADDR_W-1:0] shortTerm, baseTerm, indexTerm, dispTerm, ipTerm, sum;

  assign shortTerm = strb.useShort ? ADDR_W'(instrWord[OFFSET_W-1:0]) : '0;
  assign baseTerm  = strb.useBase  ? baseRegData : '0;
  assign indexTerm = strb.useIndex ? (indexRegData << strb.shiftAmt) : '0;
  assign dispTerm  = strb.useDisp  ? dispWord : '0;
  assign ipTerm    = strb.useIp    ? (instrAddr + ADDR_W'(IP_BIAS)) : '0;
  assign sum       = shortTerm + baseTerm + indexTerm + dispTerm + ipTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      effAddr     <= '0;
      dataReg     <= '0;
      invalidMode <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        effAddr     <= strb.invalid ? '0 : sum;
        dataReg     <= instrWord[23:19];
        invalidMode <= strb.invalid;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3
  data_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (dataReg == $past(instrWord[23:19])));
  // R12
  zero_on_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidMode) |-> (effAddr == '0));
  // R11
  mode_six_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[13:10] == MODE_RESERVED) |=> invalidMode);
endmodule

// File: rtl/memEaGen.sv
module memEaGen
  import memEaPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 5,
  parameter int IP_BIAS   = 8,
  parameter int MAX_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [31:0]        instrWord,
  input  logic [ADDR_W-1:0]  dispWord,
  input  logic [ADDR_W-1:0]  instrAddr,
  output logic [REG_W-1:0]   baseRegAddr,
  output logic [REG_W-1:0]   indexRegAddr,
  input  logic [ADDR_W-1:0]  baseRegData,
  input  logic [ADDR_W-1:0]  indexRegData,
  output logic               outValid,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [REG_W-1:0]   dataReg,
  output logic               invalidMode
);
  eaStrobes_t strb;

  assign baseRegAddr  = instrWord[18:14];
  assign indexRegAddr = instrWord[4:0];

  memEaCtrl #(.MAX_SHIFT(MAX_SHIFT)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord), .strb(strb)
  );

  memEaDatapath #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IP_BIAS(IP_BIAS)) dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .dispWord(dispWord), .instrAddr(instrAddr), .baseRegData(baseRegData),
    .indexRegData(indexRegData), .strb(strb), .outValid(outValid),
    .effAddr(effAddr), .dataReg(dataReg), .invalidMode(invalidMode)
  );
endmodule

// File: tb/memEaGen_test.sv
module memEaGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0, dispWord = '0, instrAddr = '0;
  logic [4:0]  baseRegAddr, indexRegAddr, dataReg;
  logic [31:0] baseRegData, indexRegData, effAddr;
  logic        outValid, invalidMode;
  logic [31:0] baseVal = 32'h1000_0000, idxVal = 32'h0000_0100;
  int          nRun = 0, nFail = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  assign baseRegData  = baseVal + {27'b0, baseRegAddr};
  assign indexRegData = idxVal + {27'b0, indexRegAddr};

  memEaGen uut (.*);

  task automatic checkVal(string req, string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] longWord(logic [3:0] mode, logic [2:0] sc,
      logic [4:0] dst, logic [4:0] b, logic [1:0] rsv, logic [4:0] ix);
    return {8'h90, dst, b, mode, sc, rsv, ix};
  endfunction

  function automatic logic [31:0] shortWord(logic addBase, logic [4:0] dst,
      logic [4:0] b, logic [11:0] off);
    return {8'h80, dst, b, addBase, 1'b0, off};
  endfunction

  // Independent model of R4-R12
  function automatic logic [32:0] model(logic [31:0] w, logic [31:0] d, logic [31:0] ip);
    logic [31:0] bv, iv, sc;
    bv = baseVal + {27'b0, w[18:14]};
    iv = idxVal + {27'b0, w[4:0]};
    if (!w[12]) return {1'b0, {20'b0, w[11:0]} + (w[13] ? bv : 32'h0)};
    if (w[9:7] > 3'd4 || w[6:5] != 2'b00) return {1'b1, 32'h0};
    sc = iv * (32'd1 << w[9:7]);
    case (w[13:10])
      4'd4:  return {1'b0, bv};
      4'd5:  return {1'b0, d + 32'd8 + ip};
      4'd7:  return {1'b0, bv + sc};
      4'd12: return {1'b0, d};
      4'd13: return {1'b0, d + bv};
      4'd14: return {1'b0, d + sc};
      4'd15: return {1'b0, d + bv + sc};
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  task automatic issue(string req, logic [31:0] w, logic [31:0] d, logic [31:0] ip);
    logic [32:0] e;
    @(negedge clk);
    instrWord = w; dispWord = d; instrAddr = ip; inValid = 1'b1;
    #1;
    checkVal("R2", "baseRegAddr", {27'b0, baseRegAddr}, {27'b0, w[18:14]});
    checkVal("R2", "indexRegAddr", {27'b0, indexRegAddr}, {27'b0, w[4:0]});
    e = model(w, d, ip);
    @(negedge clk);
    inValid = 1'b0;
    checkVal("R1", "outValid", {31'b0, outValid}, 32'd1);
    checkVal(req, "effAddr", effAddr, e[31:0]);
    checkVal(req, "invalidMode", {31'b0, invalidMode}, {31'b0, e[32]});
    checkVal("R3", "dataReg", {27'b0, dataReg}, {27'b0, w[23:19]});
  endtask

  task automatic testReset();
    checkVal("R1", "reset outValid", {31'b0, outValid}, 0);
    checkVal("R1", "reset effAddr", effAddr, 0);
    checkVal("R1", "reset dataReg", {27'b0, dataReg}, 0);
    checkVal("R1", "reset invalidMode", {31'b0, invalidMode}, 0);
  endtask

  task automatic testShort();
    issue("R4", shortWord(1'b0, 5'd3, 5'd9, 12'hABC), 32'hFFFF_FFFF, 32'h0);
    issue("R4", shortWord(1'b1, 5'd17, 5'd2, 12'hFFF), 32'h0, 32'h0);
    issue("R4", shortWord(1'b1, 5'd1, 5'd4, 12'h3E0), 32'h0, 32'h0);
  endtask

  task automatic testBaseAndIp();
    issue("R5", longWord(4'd4, 3'd0, 5'd6, 5'd11, 2'd0, 5'd0), 32'h0, 32'h0);
    issue("R5", longWord(4'd5, 3'd0, 5'd7, 5'd0, 2'd0, 5'd0), 32'h0000_1234, 32'h0040_0000);
  endtask

  task automatic testScaled();
    for (int s = 0; s <= 4; s++) begin
      issue("R6", longWord(4'd7, 3'(s), 5'd8, 5'd5, 2'd0, 5'd12), 32'h0, 32'h0);
      issue("R9", longWord(4'd14, 3'(s), 5'd9, 5'd0, 2'd0, 5'd31), 32'h0800_0000, 32'h0);
    end
  endtask

  task automatic testDisp();
    issue("R7", longWord(4'd12, 3'd0, 5'd10, 5'd0, 2'd0, 5'd0), 32'hDEAD_BEE0, 32'h0);
    issue("R7", longWord(4'd13, 3'd0, 5'd11, 5'd3, 2'd0, 5'd0), 32'h0000_0040, 32'h0);
    issue("R8", longWord(4'd15, 3'd3, 5'd12, 5'd6, 2'd0, 5'd2), 32'h0001_0000, 32'h0);
  endtask

  task automatic testInvalid();
    for (int s = 5; s <= 7; s++)
      issue("R9", longWord(4'd7, 3'(s), 5'd13, 5'd5, 2'd0, 5'd1), 32'h0, 32'h0);
    issue("R10", longWord(4'd12, 3'd0, 5'd14, 5'd0, 2'd1, 5'd0), 32'h1234, 32'h0);
    issue("R10", longWord(4'd4, 3'd0, 5'd15, 5'd1, 2'd2, 5'd0), 32'h0, 32'h0);
    issue("R11", longWord(4'd6, 3'd0, 5'd16, 5'd1, 2'd0, 5'd0), 32'h55, 32'h0);
  endtask

  task automatic testWrap();
    baseVal = 32'hFFFF_FF00; idxVal = 32'h8000_0000;
    issue("R12", longWord(4'd15, 3'd4, 5'd18, 5'd31, 2'd0, 5'd0), 32'hFFFF_FFF0, 32'h0);
    issue("R12", longWord(4'd5, 3'd0, 5'd19, 5'd0, 2'd0, 5'd0), 32'hFFFF_FFFC, 32'h0000_0010);
    issue("R12", shortWord(1'b1, 5'd20, 5'd31, 12'hFFF), 32'h0, 32'h0);
    baseVal = 32'h1000_0000; idxVal = 32'h0000_0100;
  endtask

  task automatic testIdle();
    @(negedge clk);
    @(negedge clk);
    checkVal("R1", "idle outValid", {31'b0, outValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testShort();
    testBaseAndIp();
    testScaled();
    testDisp();
    testInvalid();
    testWrap();
    testIdle();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule